// File: doc/BRIEF.md
# Byte-Wide Parallel FIFO Port (Device Side)

This block is the device-side end of an asynchronous byte-wide handshake port that an external microcontroller drives. The controller pulls an active-low read strobe to take a byte out of the device, and pulses an active-high write strobe to hand a byte in. Two active-low status outputs tell it when a byte is waiting and when there is room for another. Inside the chip the port feeds on a receive queue, which on-chip logic fills, and fills a transmit queue, which on-chip logic drains. Both queues are small internal arrays held inside the block.

The strobes are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and its edges are found in the clock domain. Each edge performs exactly one queue operation. After every access the matching status flag is held inactive for a programmable number of clocks, so the controller must wait for the flag to come back before it starts the next access. The bidirectional data bus is shown as separate in, out and enable signals. The pad ring joins them.

Top module: `par_fifo_port`

## Requirements
- R1: `rx_avail_n` is 1 whenever the receive queue is empty. It is 0 only when at least one byte is queued, no read strobe is active and no hold-off interval is running.
- R2: `tx_room_n` is 1 whenever the transmit queue is full. It is 0 only when the queue has room, no write strobe is active and no hold-off interval is running.
- R3: While `mcu_rd_n` is low, `mcu_d_oe` is 1 and `mcu_d_out` carries the byte fetched by that strobe. `mcu_d_oe` is 0 from the first clock edge at which `mcu_rd_n` is sampled high.
- R4: Each high-to-low transition of `mcu_rd_n` pops exactly one byte from a non-empty receive queue, in first-in first-out order.
- R5: Each high-to-low transition of `mcu_wr` pushes the byte present on `mcu_d_in` while the strobe was high into the transmit queue. One byte is pushed per strobe.
- R6: A flag goes to 1 while its strobe is active, and stays at 1 for HOLD_CLKS clocks after the strobe ends. After that it follows the queue state again.
- R7: A read strobe on an empty receive queue drives the byte last read again and changes no queue state. A later load and read return the new byte.
- R8: A write strobe on a full transmit queue drops the byte. The queue keeps its earlier contents and order.
- R9: After reset `rx_avail_n` = 1, `mcu_d_oe` = 0, `tx_room_n` = 0 and `tx_empty` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcu_rd_n | input | 1 | Read strobe from the controller, active low, asynchronous |
| mcu_wr | input | 1 | Write strobe from the controller, active high, acts on its falling edge, asynchronous |
| mcu_d_in | input | WIDTH | Data bus as seen by the device |
| mcu_d_out | output | WIDTH | Byte the device drives during a read |
| mcu_d_oe | output | 1 | Output enable for the data bus pads |
| rx_avail_n | output | 1 | Low when a byte may be read |
| tx_room_n | output | 1 | Low when a byte may be written |
| rx_load | input | 1 | On-chip push into the receive queue |
| rx_load_data | input | WIDTH | Byte to push into the receive queue |
| rx_full | output | 1 | Receive queue full; pushes are ignored while it is set |
| tx_take | input | 1 | On-chip pop from the transmit queue |
| tx_take_data | output | WIDTH | Oldest byte in the transmit queue (show-ahead) |
| tx_empty | output | 1 | Transmit queue empty |

## Verification
The bench builds the port with a queue depth of 4 and a hold-off of 3 clocks. The shallow depth lets a few directed writes fill the transmit queue, so the dropped-byte case and the full flag come within reach. The short hold-off lets the bench sample the flag both inside the forced-inactive window and after it has expired. The strobe pulses last several clocks, which covers the synchroniser delay, the fetch and the bus release on the clock after the read strobe rises.

// File: rtl/pf_pkg.sv
package pf_pkg;
   function automatic bit pf_is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int pf_cnt_bits(input int maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction
endpackage

// File: rtl/pf_strobe_sync.sv
module pf_strobe_sync #(
   parameter bit IDLE_HIGH = 1'b1,
   parameter int STAGES    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic early,
   output logic busy,
   output logic start,
   output logic stop
);
   logic              act_raw;
   logic [STAGES-1:0] chain;
   logic              prev;

   initial assert (STAGES >= 2) else $fatal(1, "pf_strobe_sync: STAGES must be at least 2");

   generate
      if (IDLE_HIGH) begin : g_act_low
         assign act_raw = ~pin;
      end else begin : g_act_high
         assign act_raw = pin;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], act_raw};
         prev  <= chain[STAGES-1];
      end
   end

   assign early = chain[0];
   assign busy  = chain[STAGES-1];
   assign start = busy & ~prev;
   assign stop  = ~busy & prev;
endmodule

// File: rtl/pf_byte_fifo.sv
module pf_byte_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);
   import pf_pkg::*;
   localparam int AW = $clog2(DEPTH);
   localparam int CW = pf_cnt_bits(DEPTH);

   initial assert (pf_is_pow2(DEPTH)) else $fatal(1, "pf_byte_fifo: DEPTH must be a power of two >= 2");

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/pf_flag_gate.sv
module pf_flag_gate #(
   parameter int HOLD_CLKS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic avail,
   input  logic busy,
   input  logic stop,
   output logic flag_n
);
   import pf_pkg::*;
   localparam int CW = pf_cnt_bits(HOLD_CLKS);

   initial assert (HOLD_CLKS >= 1) else $fatal(1, "pf_flag_gate: HOLD_CLKS must be at least 1");

   logic [CW-1:0] hold_cnt;
   logic          hold_run;

   assign hold_run = (hold_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         flag_n   <= 1'b1;
      end else begin
         if (stop)          hold_cnt <= CW'(HOLD_CLKS);
         else if (hold_run) hold_cnt <= hold_cnt - CW'(1);
         flag_n <= ~(avail & ~busy & ~stop & ~hold_run);
      end
   end
endmodule

// File: rtl/par_fifo_port.sv
module par_fifo_port #(
   parameter int WIDTH     = 8,
   parameter int DEPTH     = 16,
   parameter int HOLD_CLKS = 6,
   parameter int SYNC_FF   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mcu_rd_n,
   input  logic             mcu_wr,
   input  logic [WIDTH-1:0] mcu_d_in,
   output logic [WIDTH-1:0] mcu_d_out,
   output logic             mcu_d_oe,
   output logic             rx_avail_n,
   output logic             tx_room_n,
   input  logic             rx_load,
   input  logic [WIDTH-1:0] rx_load_data,
   output logic             rx_full,
   input  logic             tx_take,
   output logic [WIDTH-1:0] tx_take_data,
   output logic             tx_empty
);
   initial assert (WIDTH >= 1) else $fatal(1, "par_fifo_port: WIDTH must be positive");

   logic             rd_early, rd_busy, rd_start, rd_stop;
   logic             wr_early, wr_busy, wr_start, wr_stop;
   logic             rx_empty, tx_full;
   logic [WIDTH-1:0] rx_head;
   logic [WIDTH-1:0] out_q;
   logic [WIDTH-1:0] wdat_q;

   pf_strobe_sync #(.IDLE_HIGH(1'b1), .STAGES(SYNC_FF)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .pin(mcu_rd_n),
      .early(rd_early), .busy(rd_busy), .start(rd_start), .stop(rd_stop));

   pf_strobe_sync #(.IDLE_HIGH(1'b0), .STAGES(SYNC_FF)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .pin(mcu_wr),
      .early(wr_early), .busy(wr_busy), .start(wr_start), .stop(wr_stop));

   pf_byte_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_q (
      .clk(clk), .rst_n(rst_n),
      .push(rx_load), .push_data(rx_load_data),
      .pop(rd_start), .head(rx_head),
      .empty(rx_empty), .full(rx_full));

   pf_byte_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_q (
      .clk(clk), .rst_n(rst_n),
      .push(wr_stop), .push_data(wdat_q),
      .pop(tx_take), .head(tx_take_data),
      .empty(tx_empty), .full(tx_full));

   pf_flag_gate #(.HOLD_CLKS(HOLD_CLKS)) u_rx_flag (
      .clk(clk), .rst_n(rst_n), .avail(~rx_empty),
      .busy(rd_busy), .stop(rd_stop), .flag_n(rx_avail_n));

   pf_flag_gate #(.HOLD_CLKS(HOLD_CLKS)) u_tx_flag (
      .clk(clk), .rst_n(rst_n), .avail(~tx_full),
      .busy(wr_busy), .stop(wr_stop), .flag_n(tx_room_n));

   // read side: fetch on the detected falling edge, keep the last byte when empty
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     out_q <= '0;
      else if (rd_start && !rx_empty) out_q <= rx_head;
   end

   // write side: follow the bus while the strobe is high, push the held byte at its end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wdat_q <= '0;
      else if (wr_busy) wdat_q <= mcu_d_in;
   end

   assign mcu_d_out = out_q;
   assign mcu_d_oe  = rd_early;

   logic unused_ok;
   assign unused_ok = wr_early | wr_start;
endmodule

// File: rtl/par_fifo_port_chk.sv
module par_fifo_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mcu_rd_n,
   input logic             mcu_d_oe,
   input logic [WIDTH-1:0] mcu_d_out,
   input logic             rx_avail_n,
   input logic             tx_room_n,
   input logic             rx_empty,
   input logic             tx_full,
   input logic             rx_load,
   input logic             tx_take,
   input logic             rd_start,
   input logic             rd_busy,
   input logic             rd_stop,
   input logic             wr_busy,
   input logic             wr_stop,
   input logic [WIDTH-1:0] rx_head
);
   a_r1_rx_flag_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_avail_n |-> !rx_empty);

   a_r2_tx_flag_full: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_room_n |-> !tx_full);

   a_r3_bus_release: assert property (@(posedge clk) disable iff (!rst_n)
      (mcu_rd_n && $past(mcu_rd_n)) |-> !mcu_d_oe);

   a_r4_fetch_head: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && !rx_empty) |=> (mcu_d_out == $past(rx_head)));

   a_r6_rx_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rd_busy |=> rx_avail_n);

   a_r6_tx_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy |=> tx_room_n);

   a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stop |=> rx_avail_n ##1 rx_avail_n);

   a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stop |=> tx_room_n ##1 tx_room_n);

   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && rx_empty) |=> $stable(mcu_d_out));

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && !tx_take) |=> tx_full);
endmodule

bind par_fifo_port par_fifo_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .mcu_rd_n(mcu_rd_n), .mcu_d_oe(mcu_d_oe),
   .mcu_d_out(mcu_d_out), .rx_avail_n(rx_avail_n), .tx_room_n(tx_room_n),
   .rx_empty(rx_empty), .tx_full(tx_full), .rx_load(rx_load), .tx_take(tx_take),
   .rd_start(rd_start), .rd_busy(rd_busy), .rd_stop(rd_stop),
   .wr_busy(wr_busy), .wr_stop(wr_stop), .rx_head(rx_head));

// File: tb/tb_par_fifo_port.sv
module tb_par_fifo_port;
   localparam int CLK_P = 10;
   localparam int W     = 8;
   localparam int DEP   = 4;
   localparam int HOLD  = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mcu_rd_n = 1'b1;
   logic         mcu_wr = 1'b0;
   logic [W-1:0] mcu_d_in = '0;
   logic [W-1:0] mcu_d_out;
   logic         mcu_d_oe, rx_avail_n, tx_room_n, rx_full, tx_empty;
   logic         rx_load = 1'b0;
   logic [W-1:0] rx_load_data = '0;
   logic         tx_take = 1'b0;
   logic [W-1:0] tx_take_data;

   int checks = 0;
   int bad    = 0;

   always #(CLK_P/2) clk = ~clk;

   par_fifo_port #(.WIDTH(W), .DEPTH(DEP), .HOLD_CLKS(HOLD), .SYNC_FF(2)) dut (
      .clk(clk), .rst_n(rst_n), .mcu_rd_n(mcu_rd_n), .mcu_wr(mcu_wr),
      .mcu_d_in(mcu_d_in), .mcu_d_out(mcu_d_out), .mcu_d_oe(mcu_d_oe),
      .rx_avail_n(rx_avail_n), .tx_room_n(tx_room_n),
      .rx_load(rx_load), .rx_load_data(rx_load_data), .rx_full(rx_full),
      .tx_take(tx_take), .tx_take_data(tx_take_data), .tx_empty(tx_empty));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic load_rx(input logic [W-1:0] b);
      @(negedge clk); rx_load = 1'b1; rx_load_data = b;
      @(negedge clk); rx_load = 1'b0;
   endtask

   task automatic take_tx(input logic [W-1:0] exp, input string req);
      @(negedge clk);
      chk(tx_take_data == exp, req, "tx queue byte", tx_take_data, exp);
      tx_take = 1'b1;
      @(negedge clk); tx_take = 1'b0;
   endtask

   // one read cycle; checks bus, data and flag timing; more = byte left after this read
   task automatic mcu_read(input logic [W-1:0] exp, input bit more, input string req);
      @(negedge clk); mcu_rd_n = 1'b0;
      repeat (6) @(negedge clk);
      chk(mcu_d_oe == 1'b1, "R3", "oe during read", mcu_d_oe, 1);
      chk(mcu_d_out == exp, req, "read byte", mcu_d_out, exp);
      chk(rx_avail_n == 1'b1, "R6", "rx flag during strobe", rx_avail_n, 1);
      mcu_rd_n = 1'b1;
      @(negedge clk);
      chk(mcu_d_oe == 1'b0, "R3", "oe one clock after release", mcu_d_oe, 0);
      repeat (4) @(negedge clk);
      chk(rx_avail_n == 1'b1, "R6", "rx flag in hold-off", rx_avail_n, 1);
      repeat (4) @(negedge clk);
      chk(rx_avail_n == !more, "R1", "rx flag after hold-off", rx_avail_n, !more);
   endtask

   task automatic mcu_write(input logic [W-1:0] b, input bit room_after, input string req);
      @(negedge clk); mcu_d_in = b; mcu_wr = 1'b1;
      repeat (5) @(negedge clk);
      chk(tx_room_n == 1'b1, "R6", "tx flag during strobe", tx_room_n, 1);
      mcu_wr = 1'b0;
      repeat (5) @(negedge clk);
      chk(tx_room_n == 1'b1, "R6", "tx flag in hold-off", tx_room_n, 1);
      repeat (4) @(negedge clk);
      chk(tx_room_n == !room_after, req, "tx flag after hold-off", tx_room_n, !room_after);
      mcu_d_in = '0;
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(rx_avail_n == 1'b1, "R9", "rx flag after reset", rx_avail_n, 1);
      chk(mcu_d_oe == 1'b0, "R9", "oe after reset", mcu_d_oe, 0);
      chk(tx_room_n == 1'b0, "R9", "tx flag after reset", tx_room_n, 0);
      chk(tx_empty == 1'b1, "R9", "tx empty after reset", tx_empty, 1);
   endtask

   task automatic t_read_order;
      load_rx(8'hA5); load_rx(8'h3C); load_rx(8'h71);
      repeat (2) @(negedge clk);
      chk(rx_avail_n == 1'b0, "R1", "rx flag with data", rx_avail_n, 0);
      mcu_read(8'hA5, 1'b1, "R4");
      mcu_read(8'h3C, 1'b1, "R4");
      mcu_read(8'h71, 1'b0, "R4");
   endtask

   task automatic t_read_empty;
      mcu_read(8'h71, 1'b0, "R7");
      load_rx(8'hE2);
      repeat (2) @(negedge clk);
      mcu_read(8'hE2, 1'b0, "R7");
   endtask

   task automatic t_write;
      mcu_write(8'h5A, 1'b1, "R5");
      mcu_write(8'hC3, 1'b1, "R5");
      take_tx(8'h5A, "R5");
      take_tx(8'hC3, "R5");
      chk(tx_empty == 1'b1, "R5", "tx empty after draining", tx_empty, 1);
   endtask

   task automatic t_write_full;
      mcu_write(8'h11, 1'b1, "R2");
      mcu_write(8'h22, 1'b1, "R2");
      mcu_write(8'h33, 1'b1, "R2");
      mcu_write(8'h44, 1'b0, "R2");
      mcu_write(8'h99, 1'b0, "R8");
      take_tx(8'h11, "R8");
      take_tx(8'h22, "R8");
      take_tx(8'h33, "R8");
      take_tx(8'h44, "R8");
      chk(tx_empty == 1'b1, "R8", "dropped byte not stored", tx_empty, 1);
      repeat (2) @(negedge clk);
      chk(tx_room_n == 1'b0, "R2", "tx flag after draining", tx_room_n, 0);
   endtask

   initial begin
      t_reset();
      t_read_order();
      t_read_empty();
      t_write();
      t_write_full();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule